// File: doc/BRIEF.md
# Low-Power Retention Mode Unlock Detector

This block sits on the access path of a pseudo-static memory. It watches each access presented to the array and picks out a fixed six-access pattern that programs the retention mode used when the part is later powered down. Each access arrives as a single-cycle event carrying direction, a 21-bit word address, two active-low byte strobes, the write data, and the data that the array returned for a read. The block decides on every write whether the array must perform it, perform it with substituted data, skip it, or treat its contents as undefined. It also holds the selected retention mode.

The pattern has six steps. The first is a read of the all-ones address. Two writes to that address follow, then two more writes to it. The last step is a read whose address is the mode key; the data that read returns has no meaning. The two early writes store the word captured by the first read, so the top word is preserved. The two late writes are absorbed. A wrong access during the early writes cancels the pattern cleanly. A wrong write during the late writes cancels it with its data marked undefined. A query port tells the power controller whether a given address is kept in the current mode.

Top module: `lpm_unlock_detect`

## Requirements
- R1: After reset `mode_o` is 0 (full sleep, nothing retained), and `key_err_o`, `lost_o`, `wr_en_o` and `wr_undef_o` are low.
- R2: Read all-ones, four writes to all-ones, then a read of key K sets `mode_o` on the clock edge that ends the key read. The keys are: 1FFFFFh gives mode 0, 17FFFFh gives mode 1 (words 000000h-03FFFFh kept), and 0FFFFFh gives mode 2 (words 000000h-07FFFFh kept).
- R3: The writes at steps 2 and 3 raise `wr_en_o` in their own cycle, with `wr_data_o` equal to the read data captured at step 1.
- R4: The writes at steps 4 and 5 are absorbed: `wr_en_o` and `wr_undef_o` stay low.
- R5: A write to any other address at step 2 or 3 cancels the pattern and is forwarded as an ordinary write (`wr_en_o` high, `wr_data_o` equal to the write data).
- R6: A write to any other address at step 4 or 5 cancels the pattern, keeps `wr_en_o` low and raises `wr_undef_o` for that cycle.
- R7: Any other non-matching access returns the detector to idle. The exception is a read of all-ones, which restarts the pattern as step 1 and captures that read's data.
- R8: An access with both byte strobes high (`acc_be_n_i` = 2'b11) is ignored: it causes no write, no flag and no step change. Any other strobe value counts as an access.
- R9: A key read whose top two address bits are 00, or whose lower 19 bits are not all ones, leaves `mode_o` unchanged and pulses `key_err_o` for one cycle.
- R10: A key that moves `mode_o` directly between 1 and 2 pulses `lost_o` for one cycle. There is no pulse when the mode stays the same or when mode 0 is the old or new mode.
- R11: `qry_keep_o` is 0 in mode 0. In mode 1 it is high only for `qry_addr_i` < 040000h, and in mode 2 only for `qry_addr_i` < 080000h.
- R12: Outside the pattern, writes are forwarded unchanged and reads never raise `wr_en_o` or `wr_undef_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | One access event this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 21 | Word address of the access |
| acc_be_n_i | input | 2 | Byte strobes, active low (bit 0 low byte) |
| acc_wdata_i | input | 16 | Write data |
| acc_rdata_i | input | 16 | Data the array returned for a read |
| qry_addr_i | input | 21 | Address to test for retention |
| wr_en_o | output | 1 | Array must perform this write |
| wr_data_o | output | 16 | Data the array must store |
| wr_undef_o | output | 1 | Write cancelled late; stored data undefined |
| mode_o | output | 2 | Retention mode: 0 sleep, 1 small range, 2 large range |
| key_err_o | output | 1 | One-cycle pulse on an unknown key |
| lost_o | output | 1 | One-cycle pulse on a change between the two partial modes |
| qry_keep_o | output | 1 | `qry_addr_i` is retained in the current mode |

## Verification
Assertions check the following on every cycle: mode 3 never appears; a write is never both performed and undefined; reads and strobe-less accesses never cause a write; an error pulse leaves the mode unchanged; a loss pulse comes only with a move between the two partial modes; and nothing is retained in sleep mode. Only the bench scenarios can show the step sequencing itself. That covers correct completion for each key, the restored data at steps 2 and 3, the different cancel outcomes at early and late steps, restart on an all-ones read, and the range boundaries of the retention query. The bench tracks these against a model of the requirements across random and directed traffic.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_RET_S = 2'd1,
    MODE_RET_L = 2'd2
  } lp_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_W2   = 3'd1,
    ST_W3   = 3'd2,
    ST_W4   = 3'd3,
    ST_W5   = 3'd4,
    ST_KEY  = 3'd5
  } seq_st_e;

  function automatic logic is_partial(lp_mode_e m);
    return (m == MODE_RET_S) || (m == MODE_RET_L);
  endfunction
endpackage

// File: rtl/lpm_key_decode.sv
module lpm_key_decode
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic [ADDR_W-1:0] key_i,
  output logic              key_ok_o,
  output lp_mode_e          key_mode_o
);
  localparam int LOW_W = ADDR_W - 2;

  logic          low_ones;
  logic [1:0]    sel;

  assign low_ones = &key_i[LOW_W-1:0];
  assign sel      = key_i[ADDR_W-1:ADDR_W-2];

  always_comb begin
    key_ok_o   = low_ones;
    key_mode_o = MODE_SLEEP;
    unique case (sel)
      2'b11:   key_mode_o = MODE_SLEEP;
      2'b10:   key_mode_o = MODE_RET_S;
      2'b01:   key_mode_o = MODE_RET_L;
      default: key_ok_o   = 1'b0;
    endcase
  end

  always_comb begin
    a_ok_low_ones_r9 : assert (!key_ok_o || low_ones);
  end
endmodule

// File: rtl/lpm_retain_qual.sv
module lpm_retain_qual
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lp_mode_e          mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              keep_o
);
  // small range = 2^(ADDR_W-3) words, large range = 2^(ADDR_W-2) words
  localparam int S_TOP = 3;
  localparam int L_TOP = 2;

  logic in_small, in_large;

  assign in_small = (addr_i[ADDR_W-1 -: S_TOP] == '0);
  assign in_large = (addr_i[ADDR_W-1 -: L_TOP] == '0);

  always_comb begin
    unique case (mode_i)
      MODE_RET_S: keep_o = in_small;
      MODE_RET_L: keep_o = in_large;
      default:    keep_o = 1'b0;
    endcase
  end

  p_sleep_keeps_none_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SLEEP) |-> !keep_o);
  p_small_in_large_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RET_L && in_small) |-> keep_o);
endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_be_n_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  logic [DATA_W-1:0] acc_rdata_i,
  input  logic              key_ok_i,
  input  lp_mode_e          key_mode_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_undef_o,
  output lp_mode_e          mode_o,
  output logic              key_err_o,
  output logic              lost_o
);
  seq_st_e           st_q, st_d;
  lp_mode_e          mode_q, mode_d;
  logic [DATA_W-1:0] rda_q, rda_d;
  logic              err_d, lost_d;
  logic              live, top_addr, top_rd, top_wr;

  assign live     = acc_valid_i && (acc_be_n_i != 2'b11);
  assign top_addr = &acc_addr_i;
  assign top_rd   = live && !acc_write_i && top_addr;
  assign top_wr   = live && acc_write_i && top_addr;

  always_comb begin
    st_d       = st_q;
    rda_d      = rda_q;
    mode_d     = mode_q;
    err_d      = 1'b0;
    lost_d     = 1'b0;
    wr_en_o    = live && acc_write_i;
    wr_data_o  = acc_wdata_i;
    wr_undef_o = 1'b0;
    if (live) begin
      unique case (st_q)
        ST_IDLE: begin
          if (top_rd) begin
            st_d  = ST_W2;
            rda_d = acc_rdata_i;
          end
        end
        ST_W2, ST_W3: begin
          if (top_wr) begin
            st_d      = (st_q == ST_W2) ? ST_W3 : ST_W4;
            wr_data_o = rda_q;  // keep top word intact
          end else begin
            st_d  = top_rd ? ST_W2 : ST_IDLE;
            rda_d = top_rd ? acc_rdata_i : rda_q;
          end
        end
        ST_W4, ST_W5: begin
          if (top_wr) begin
            st_d    = (st_q == ST_W4) ? ST_W5 : ST_KEY;
            wr_en_o = 1'b0;
          end else if (acc_write_i) begin
            st_d       = ST_IDLE;
            wr_en_o    = 1'b0;
            wr_undef_o = 1'b1;
          end else begin
            st_d  = top_rd ? ST_W2 : ST_IDLE;
            rda_d = top_rd ? acc_rdata_i : rda_q;
          end
        end
        ST_KEY: begin
          st_d = ST_IDLE;
          if (!acc_write_i) begin
            if (key_ok_i) begin
              mode_d = key_mode_i;
              lost_d = is_partial(mode_q) && is_partial(key_mode_i) &&
                       (mode_q != key_mode_i);
            end else begin
              err_d = 1'b1;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      mode_q    <= MODE_SLEEP;
      rda_q     <= '0;
      key_err_o <= 1'b0;
      lost_o    <= 1'b0;
    end else begin
      st_q      <= st_d;
      mode_q    <= mode_d;
      rda_q     <= rda_d;
      key_err_o <= err_d;
      lost_o    <= lost_d;
    end
  end

  assign mode_o = mode_q;

  p_mode_legal_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'd3);
  p_wr_excl_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && wr_undef_o));
  p_read_no_write_r12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i) |-> (!wr_en_o && !wr_undef_o));
  p_strobe_ignored_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_be_n_i == 2'b11) |=> ($stable(st_q) && !key_err_o && !lost_o));
  p_err_holds_mode_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_err_o |-> (mode_q == $past(mode_q)));
  p_lost_partial_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> (is_partial(mode_q) && is_partial(lp_mode_e'($past(mode_q))) &&
                mode_q != $past(mode_q)));
  p_no_err_and_lost_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(key_err_o && lost_o));
endmodule

// File: rtl/lpm_unlock_detect.sv
module lpm_unlock_detect
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_be_n_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  logic [DATA_W-1:0] acc_rdata_i,
  input  logic [ADDR_W-1:0] qry_addr_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_undef_o,
  output logic [1:0]        mode_o,
  output logic              key_err_o,
  output logic              lost_o,
  output logic              qry_keep_o
);
  logic     key_ok;
  lp_mode_e key_mode, mode;

  lpm_key_decode #(.ADDR_W(ADDR_W)) u_key (
    .key_i      (acc_addr_i),
    .key_ok_o   (key_ok),
    .key_mode_o (key_mode)
  );

  lpm_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .acc_addr_i  (acc_addr_i),
    .acc_be_n_i  (acc_be_n_i),
    .acc_wdata_i (acc_wdata_i),
    .acc_rdata_i (acc_rdata_i),
    .key_ok_i    (key_ok),
    .key_mode_i  (key_mode),
    .wr_en_o     (wr_en_o),
    .wr_data_o   (wr_data_o),
    .wr_undef_o  (wr_undef_o),
    .mode_o      (mode),
    .key_err_o   (key_err_o),
    .lost_o      (lost_o)
  );

  lpm_retain_qual #(.ADDR_W(ADDR_W)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .addr_i (qry_addr_i),
    .keep_o (qry_keep_o)
  );

  assign mode_o = mode;
endmodule

// File: tb/tb_lpm_unlock_detect.sv
`timescale 1ns/1ps
module tb_lpm_unlock_detect;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam logic [AW-1:0] TOP = '1;
  localparam logic [AW-1:0] K_S = 21'h17FFFF;
  localparam logic [AW-1:0] K_L = 21'h0FFFFF;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [AW-1:0] acc_addr = '0, qry_addr = '0;
  logic [1:0] acc_be_n = 2'b00;
  logic [DW-1:0] acc_wdata = '0, acc_rdata = '0;
  logic wr_en, wr_undef, key_err, lost, qry_keep;
  logic [DW-1:0] wr_data;
  logic [1:0] mode;

  always #10 clk = ~clk;

  lpm_unlock_detect dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_addr_i(acc_addr), .acc_be_n_i(acc_be_n), .acc_wdata_i(acc_wdata),
    .acc_rdata_i(acc_rdata), .qry_addr_i(qry_addr), .wr_en_o(wr_en),
    .wr_data_o(wr_data), .wr_undef_o(wr_undef), .mode_o(mode),
    .key_err_o(key_err), .lost_o(lost), .qry_keep_o(qry_keep)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_step = 0;            // 0 idle, 1..5 = number of steps already matched
  int m_mode = 0;
  logic [DW-1:0] m_rda = '0;
  bit e_wen, e_undef, e_err, e_lost;
  logic [DW-1:0] e_wdata;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_keep(int md, logic [AW-1:0] a);
    if (md == 1) return a < 21'h040000;
    if (md == 2) return a < 21'h080000;
    return 1'b0;
  endfunction

  // model from the requirements
  task automatic model(bit w, logic [AW-1:0] a, logic [1:0] be, logic [DW-1:0] wd,
                       logic [DW-1:0] rd);
    bit top = (a == TOP);
    int nm;
    e_wen = 0; e_undef = 0; e_err = 0; e_lost = 0; e_wdata = wd;
    if (be == 2'b11) return;                       // R8
    e_wen = w;                                     // R12 default
    if (m_step == 0) begin
      if (!w && top) begin m_step = 1; m_rda = rd; end
    end else if (m_step == 1 || m_step == 2) begin
      if (w && top) begin m_step++; e_wdata = m_rda; end     // R3
      else if (!w && top) begin m_step = 1; m_rda = rd; end  // R7
      else m_step = 0;                                       // R5
    end else if (m_step == 3 || m_step == 4) begin
      if (w && top) begin m_step++; e_wen = 0; end           // R4
      else if (w) begin m_step = 0; e_wen = 0; e_undef = 1; end // R6
      else if (top) begin m_step = 1; m_rda = rd; end
      else m_step = 0;
    end else begin
      m_step = 0;
      if (!w) begin
        if (a[AW-3:0] != '1 || a[AW-1:AW-2] == 2'b00) e_err = 1; // R9
        else begin
          nm = (a[AW-1:AW-2] == 2'b11) ? 0 : (a[AW-1:AW-2] == 2'b10) ? 1 : 2;
          e_lost = (m_mode != 0) && (nm != 0) && (nm != m_mode);  // R10
          m_mode = nm;
        end
      end
    end
  endtask

  task automatic access(bit w, logic [AW-1:0] a, logic [1:0] be, logic [DW-1:0] wd,
                        logic [DW-1:0] rd, logic [AW-1:0] q);
    acc_valid = 1; acc_write = w; acc_addr = a; acc_be_n = be;
    acc_wdata = wd; acc_rdata = rd;
    model(w, a, be, wd, rd);
    #1;
    chk(wr_en == e_wen, "R3/R4/R5/R12 wr_en", wr_en, e_wen);
    chk(wr_undef == e_undef, "R6 wr_undef", wr_undef, e_undef);
    if (e_wen) chk(wr_data == e_wdata, "R3/R5 wr_data", wr_data, e_wdata);
    @(posedge clk); @(negedge clk);
    acc_valid = 0;
    qry_addr = q;
    #1;
    chk(mode == 2'(m_mode), "R2 mode", mode, m_mode);
    chk(key_err == e_err, "R9 key_err", key_err, e_err);
    chk(lost == e_lost, "R10 lost", lost, e_lost);
    chk(qry_keep == exp_keep(m_mode, q), "R11 keep", qry_keep, exp_keep(m_mode, q));
  endtask

  task automatic run_seq(logic [AW-1:0] key, logic [DW-1:0] rda);
    access(0, TOP, 2'b00, 16'h0, rda, 21'h03FFFF);
    access(1, TOP, 2'b10, 16'h1111, 16'h0, 21'h040000);
    access(1, TOP, 2'b00, 16'h2222, 16'h0, 21'h07FFFF);
    access(1, TOP, 2'b00, 16'h3333, 16'h0, 21'h080000);
    access(1, TOP, 2'b01, 16'h4444, 16'h0, 21'h000000);
    access(0, key, 2'b00, 16'h0, 16'hDEAD, 21'h03FFFF);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    #5;
    chk(mode == 2'd0, "R1 mode", mode, 0);
    chk(!key_err && !lost && !wr_en && !wr_undef, "R1 flags", {key_err, lost, wr_en, wr_undef}, 0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    run_seq(K_S, 16'hA5A5);                 // R2 small
    run_seq(K_L, 16'h5A5A);                 // R2 large, R10 lost
    run_seq(K_L, 16'h0F0F);                 // R10 no lost on same
    run_seq(21'h07FFFF, 16'h1234);          // R9 invalid top bits
    run_seq(21'h17FFFE, 16'h1234);          // R9 low bit clear
    run_seq(TOP, 16'hBEEF);                 // R2 sleep
    run_seq(K_L, 16'hCAFE);                 // R10 from sleep, no lost
    run_seq(K_S, 16'hCAFE);                 // R10 lost
    // R5 early cancel then remaining steps must not program
    access(0, TOP, 2'b00, 0, 16'h7777, 0);
    access(1, 21'h000123, 2'b00, 16'h9999, 0, 0);
    access(1, TOP, 2'b00, 1, 0, 0);
    // R6 late cancel
    access(0, TOP, 2'b00, 0, 16'h8888, 0);
    access(1, TOP, 2'b00, 1, 0, 0);
    access(1, TOP, 2'b00, 1, 0, 0);
    access(1, 21'h000055, 2'b00, 16'h6666, 0, 0);
    access(0, K_L, 2'b00, 0, 0, 0);
    // R8 strobe-less access mid-sequence, R7 restart
    access(0, TOP, 2'b00, 0, 16'h1357, 0);
    access(1, 21'h000001, 2'b11, 16'h2468, 0, 0);
    access(1, TOP, 2'b00, 0, 0, 0);
    access(0, TOP, 2'b00, 0, 16'h9753, 0);
    access(1, TOP, 2'b00, 0, 0, 0);
    access(1, TOP, 2'b00, 0, 0, 0);
    access(1, TOP, 2'b11, 0, 0, 0);
    access(1, TOP, 2'b00, 0, 0, 0);
    access(1, TOP, 2'b00, 0, 0, 0);
    access(0, K_L, 2'b00, 0, 0, 21'h07FFFF);

    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic [AW-1:0] a;
      logic [1:0] be;
      if (i % 200 == 0) begin
        int k = $urandom_range(0, 3);
        run_seq(k == 0 ? TOP : k == 1 ? K_S : k == 2 ? K_L : 21'h05FFFF, 16'($urandom));
      end
      if (r < 45) a = TOP;
      else if (r < 55) a = K_S;
      else if (r < 65) a = K_L;
      else a = AW'($urandom);
      be = ($urandom_range(0, 7) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
      access(bit'($urandom_range(0, 1)), a, be, 16'($urandom), 16'($urandom), AW'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule